// File: doc/BRIEF.md
# Dual-Mode Single-Digit Multiplier

This block multiplies two 4-bit operands in pure combinational logic. One mode pin sets how the operands and the result are read. In decimal mode each operand is one BCD digit and the result is the product written as two BCD digits. In binary mode each operand is a hexadecimal value from 0 to 15 and the result is the plain 8-bit unsigned product.

Both modes share one datapath. The operand is shifted to form its multiples by one, two, four and eight. The multiples selected by the bits of the other operand are summed. In decimal mode that sum goes through a shift-and-correct network that turns it into BCD. Nothing is precomputed or stored. A decimal operand above 9 is flagged, and the decimal result is then forced to zero.

The block is meant as the digit cell of a wider decimal or hexadecimal multiplier. The caller collects the partial products of several cells.

Top module: `dms_digit_mul`

## Requirements
- R1: In decimal mode with both operands in 0..9, result bits [3:0] hold the units digit and bits [7:4] hold the tens digit of the product.
- R2: In decimal mode with valid operands, each result nibble is at most 9. The largest result, 9 times 9, reads 0x81.
- R3: In binary mode, the result equals the unsigned 8-bit product of the two operands, from 0 to 225.
- R4: In decimal mode, the invalid flag is 1 exactly when either operand is greater than 9.
- R5: In decimal mode, while the invalid flag is 1, the result is 0x00.
- R6: In binary mode, the invalid flag is 0 for every operand pair, and operands from 10 to 15 multiply like any other value.
- R7: If either operand is zero, the result is 0x00 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_dec_i | input | 1 | 1 selects decimal mode, 0 selects binary mode |
| op_a_i | input | 4 | First operand |
| op_b_i | input | 4 | Second operand |
| result_o | output | 8 | Two BCD digits (tens high) or the binary product |
| bad_bcd_o | output | 1 | In decimal mode, set when an operand is not a BCD digit |

## Verification
The hardest cases to reach are the ones where one operand is a valid digit and the other is not, for example 9 with 10. Here the product is small and looks plausible, so only the flag and the forced zero separate a correct result from a wrong one. The same operands must then multiply normally once the mode pin changes. The stimulus covers every one of the 256 operand pairs in both modes, so each mixed case is applied in both modes. The 9 times 9 pair, which gives the largest decimal carry, is included in that sweep.

// File: rtl/dms_pkg.sv
package dms_pkg;
    parameter int DIGIT_W = 4;
    localparam int PROD_W = 2 * DIGIT_W;
    localparam int BCD_DIGITS = 2;
    localparam int BCD_MAX = 9;

    typedef struct packed {
        logic [PROD_W-1:0] value;
        logic              bad;
    } dms_out_t;
endpackage

// File: rtl/dms_digit_check.sv
module dms_digit_check #(
    parameter int W     = dms_pkg::DIGIT_W,
    parameter int N_OPS = 2
) (
    input  logic             en_i,
    input  logic [N_OPS*W-1:0] ops_i,
    output logic             bad_o
);
    localparam logic [W-1:0] LIMIT = W'(dms_pkg::BCD_MAX);

    logic [N_OPS-1:0] over_d;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        assign over_d[g] = (ops_i[g*W +: W] > LIMIT);
    end

    assign bad_o = en_i & (|over_d);
endmodule

// File: rtl/dms_pp_mult.sv
module dms_pp_mult #(
    parameter int W = dms_pkg::DIGIT_W
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] MAX_PROD = PW'((2**W - 1) * (2**W - 1));

    logic [PW-1:0] acc_d;

    always_comb begin
        logic [PW-1:0] multiple;
        acc_d = '0;
        for (int i = 0; i < W; i++) begin
            multiple = {{W{1'b0}}, a_i} << i;
            if (b_i[i]) begin
                acc_d = acc_d + multiple;
            end
        end
        if (a_i == '0 || b_i == '0) begin
            assert_zero_operand_R7: assert (acc_d == '0)
                else $error("partial product sum nonzero with zero operand");
        end
        assert_product_range_R3: assert (acc_d <= MAX_PROD)
            else $error("partial product sum beyond largest product");
    end

    assign prod_o = acc_d;
endmodule

// File: rtl/dms_bin2bcd.sv
module dms_bin2bcd #(
    parameter int IN_W = dms_pkg::PROD_W,
    parameter int NDIG = dms_pkg::BCD_DIGITS
) (
    input  logic [IN_W-1:0]   bin_i,
    output logic [4*NDIG-1:0] bcd_o
);
    localparam int SW    = IN_W + 4 * NDIG;
    localparam int LIMIT = 10 ** NDIG;

    logic [SW-1:0] shreg_d;

    always_comb begin
        shreg_d = {{(4*NDIG){1'b0}}, bin_i};
        for (int i = 0; i < IN_W; i++) begin
            for (int d = 0; d < NDIG; d++) begin
                if (shreg_d[IN_W + 4*d +: 4] >= 4'd5) begin
                    shreg_d[IN_W + 4*d +: 4] = shreg_d[IN_W + 4*d +: 4] + 4'd3;
                end
            end
            shreg_d = shreg_d << 1;
        end
        if (32'(bin_i) < LIMIT) begin
            for (int d = 0; d < NDIG; d++) begin
                assert_digit_range_R2: assert (shreg_d[IN_W + 4*d +: 4] <= 4'd9)
                    else $error("BCD digit %0d above nine", d);
            end
            assert_units_digit_R1: assert (IN_W'(shreg_d[IN_W +: 4]) == bin_i % IN_W'(10))
                else $error("units digit does not match remainder by ten");
        end
    end

    assign bcd_o = shreg_d[IN_W +: 4*NDIG];
endmodule

// File: rtl/dms_digit_mul.sv
module dms_digit_mul
    import dms_pkg::*;
(
    input  logic               mode_dec_i,
    input  logic [DIGIT_W-1:0] op_a_i,
    input  logic [DIGIT_W-1:0] op_b_i,
    output logic [PROD_W-1:0]  result_o,
    output logic               bad_bcd_o
);
    logic [PROD_W-1:0]       prod_d;
    logic [4*BCD_DIGITS-1:0] bcd_d;
    logic                    bad_d;
    dms_out_t                res_d;

    dms_pp_mult #(.W(DIGIT_W)) u_mult (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .prod_o (prod_d)
    );

    dms_bin2bcd #(.IN_W(PROD_W), .NDIG(BCD_DIGITS)) u_conv (
        .bin_i (prod_d),
        .bcd_o (bcd_d)
    );

    dms_digit_check #(.W(DIGIT_W), .N_OPS(2)) u_check (
        .en_i  (mode_dec_i),
        .ops_i ({op_b_i, op_a_i}),
        .bad_o (bad_d)
    );

    always_comb begin
        res_d.bad = bad_d;
        if (!mode_dec_i) begin
            res_d.value = prod_d;
        end else if (bad_d) begin
            res_d.value = '0;
        end else begin
            res_d.value = PROD_W'(bcd_d);
        end
    end

    assign result_o  = res_d.value;
    assign bad_bcd_o = res_d.bad;
endmodule

// File: tb/dms_digit_mul_tb.sv
module dms_digit_mul_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_dec;
    logic [3:0] op_a;
    logic [3:0] op_b;
    logic [7:0] result;
    logic       bad;

    int checks = 0;
    int errors = 0;
    bit driving_done = 1'b0;

    typedef struct {
        logic       mode;
        logic [3:0] a;
        logic [3:0] b;
        logic [7:0] exp_res;
        logic       exp_bad;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    dms_digit_mul u_dut (
        .mode_dec_i (mode_dec),
        .op_a_i     (op_a),
        .op_b_i     (op_b),
        .result_o   (result),
        .bad_bcd_o  (bad)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic m, input int a, input int b);
        item_t it;
        int p;
        @(posedge clk);
        #1;
        mode_dec = m;
        op_a = 4'(a);
        op_b = 4'(b);
        p = a * b;
        it.mode = m;
        it.a = 4'(a);
        it.b = 4'(b);
        if (m && (a > 9 || b > 9)) begin
            it.exp_bad = 1'b1;
            it.exp_res = 8'h00;
        end else if (m) begin
            it.exp_bad = 1'b0;
            it.exp_res = {4'(p / 10), 4'(p % 10)};
        end else begin
            it.exp_bad = 1'b0;
            it.exp_res = 8'(p);
        end
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                if (it.mode && it.exp_bad) begin
                    check("R4 flag on non-digit", {7'd0, bad}, 8'd1);
                    check("R5 forced zero", result, it.exp_res);
                end else if (it.mode) begin
                    check("R4 flag clear on digits", {7'd0, bad}, 8'd0);
                    check("R1 tens/units product", result, it.exp_res);
                    check("R2 nibble range", {7'd0, (result[7:4] > 4'd9) || (result[3:0] > 4'd9)}, 8'd0);
                end else begin
                    check("R6 flag low in binary", {7'd0, bad}, 8'd0);
                    check("R3 binary product", result, it.exp_res);
                end
                if (it.a == 4'd0 || it.b == 4'd0) begin
                    check("R7 zero operand", result, 8'h00);
                end
            end
        end
    end

    initial begin : driver
        mode_dec = 1'b0;
        op_a = 4'd0;
        op_b = 4'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle zero output", result, 8'h00);
        check("R6 idle flag", {7'd0, bad}, 8'd0);
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    drive(1'(m), a, b);
                end
            end
        end
        drive(1'b1, 9, 9);
        drive(1'b0, 15, 15);
        drive(1'b1, 9, 10);
        drive(1'b0, 9, 10);
        @(posedge clk);
        #1;
        mode_dec = 1'b1;
        op_a = 4'd9;
        op_b = 4'd9;
        @(negedge clk);
        check("R2 largest decimal 0x81", result, 8'h81);
        repeat (2) @(posedge clk);
        driving_done = 1'b1;
    end

    initial begin : watchdog
        int cyc = 0;
        while (!driving_done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!driving_done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule